// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block models a small flash array together with its program, erase and access-protection control. A requester issues one command per cycle on a simple valid/opcode/address port: a data read, an instruction fetch, a debug read, a single-word program, a buffered program, or a block erase. The array is held in registers inside the block. It resets to the erased state of all ones. Programming can only clear bits. Erase restores a whole erase block to ones.

Protection is applied per region, and each region holds two adjacent erase blocks. Each region has a program-enable bit and a read-enable bit, supplied as vectors in which bit n governs region n. With program-enable set, the region may be altered. With program-enable clear and read-enable set, the region is read-only. With both bits clear, the region is execute-only and answers instruction fetches alone. A refused command leaves the array untouched and raises a one-cycle violation flag. A refused read also returns zero. Program and erase hold `busy` high for a modelled duration, and the block ignores any command presented during that time.

The buffered program takes its data from an internal write buffer. The requester fills this buffer beforehand through a separate index/data port.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset every word reads 0xFFFFFFFF, `busy`, `viol` and `rd_valid` are low, and every write-buffer entry holds 0xFFFFFFFF.
- R2: Opcode 4 (program word) with program-enable set replaces the addressed word with its old value ANDed with `wdata`, so bits only go from 1 to 0.
- R3: Opcode 5 (buffered program) ANDs write-buffer entry i into word base+i for all BUF_LEN words, where base is `addr` with its low log2(BUF_LEN) bits cleared. Buffer entries are loaded with `buf_we`/`buf_idx`/`buf_wdata` at any time. `busy` stays high for BUF_LEN*PROG_CYC/2 cycles, which is half the time of BUF_LEN single programs.
- R4: Opcode 6 (erase) sets all BLK_WORDS words of the erase block holding `addr` to 0xFFFFFFFF and leaves the other block of the same region unchanged.
- R5: The region of an address is `addr >> log2(2*BLK_WORDS)`. Bit n of `prog_en`/`read_en` applies to region n only, so neighbouring regions are unaffected.
- R6: When `prog_en[region]` is 0, opcodes 4, 5 and 6 are refused. A refused write leaves the array unchanged, does not raise `busy`, and pulses `viol`.
- R7: A read-only region (`prog_en`=0, `read_en`=1) returns stored data for opcode 1 (data read), opcode 3 (debug read) and opcode 2 (fetch) without violation.
- R8: When `read_en[region]` is 0, opcode 2 (fetch) still returns stored data. Opcodes 1 and 3 are refused: `rd_valid` is 1, `rdata` is 0 and `viol` is 1.
- R9: The response to an accepted command appears in the cycle after the accepting edge and lasts one cycle. `rd_valid` is high for read opcodes 1, 2 and 3. `viol` is high exactly when the command was refused.
- R10: An accepted program holds `busy` for PROG_CYC cycles and an erase for ERASE_CYC cycles. A command presented while `busy` is high has no effect: no `rd_valid`, no `viol`, and no change to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 3 | Opcode: 0 none, 1 read, 2 fetch, 3 debug read, 4 program, 5 buffered program, 6 erase |
| addr | input | AW (8) | Word address |
| wdata | input | 32 | Program data for opcode 4 |
| buf_we | input | 1 | Write-buffer load strobe |
| buf_idx | input | log2(BUF_LEN) (5) | Write-buffer entry index |
| buf_wdata | input | 32 | Write-buffer load data |
| prog_en | input | NREG (4) | Program-enable bit per region |
| read_en | input | NREG (4) | Read-enable bit per region |
| busy | output | 1 | Program or erase in progress |
| rd_valid | output | 1 | Read response valid |
| rdata | output | 32 | Read data, zero when refused |
| viol | output | 1 | One-cycle access-violation flag |

## Verification
The assertions check on every cycle that a refused command produces a violation and that each violation traces back to one. They also check that refused reads carry zero data, that fetches are never refused, that an accepted write raises `busy`, that no array write happens in a region whose program-enable bit is clear, and that commands presented while busy produce no response. The bench scenarios are the only place where the data side shows up. They confirm the AND-only programming result, the buffer-to-array mapping with its aligned base, erase confined to one half of a region, the exact `busy` durations, and that ignored or refused commands left the array untouched when it is read back later.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_FETCH = 3'd2,
    OP_DEBUG = 3'd3,
    OP_PROG  = 3'd4,
    OP_BUFP  = 3'd5,
    OP_ERASE = 3'd6,
    OP_RSVD  = 3'd7
  } fop_e;

  // Flash cells can only be pulled from 1 to 0.
  function automatic logic [31:0] cell_program(input logic [31:0] old_w,
                                               input logic [31:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic op_is_read(input fop_e op);
    return (op == OP_READ) || (op == OP_FETCH) || (op == OP_DEBUG);
  endfunction

  function automatic logic op_is_write(input fop_e op);
    return (op == OP_PROG) || (op == OP_BUFP) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/fpc_prot_check.sv
module fpc_prot_check
  import flash_prot_pkg::*;
#(
  parameter int NREG = 4,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  fop_e            op,
  input  logic [RW-1:0]   region,
  input  logic [NREG-1:0] prog_en,
  input  logic [NREG-1:0] read_en,
  output logic            is_read,
  output logic            is_write,
  output logic            allow
);
  assign is_read  = op_is_read(op);
  assign is_write = op_is_write(op);

  always_comb begin
    unique case (op)
      OP_READ, OP_DEBUG:        allow = read_en[region];
      OP_FETCH:                 allow = 1'b1;
      OP_PROG, OP_BUFP, OP_ERASE: allow = prog_en[region];
      default:                  allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpc_timer.sv
module fpc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/fpc_store.sv
module fpc_store
  import flash_prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_WORDS  = 32,
  parameter int BUF_LEN    = 32,
  localparam int WORDS  = NUM_BLOCKS * BLK_WORDS,
  localparam int AW     = $clog2(WORDS),
  localparam int BLK_SH = $clog2(BLK_WORDS),
  localparam int BUF_SH = $clog2(BUF_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  input  logic              do_prog,
  input  logic              do_bufp,
  input  logic              do_erase,
  input  logic              buf_we,
  input  logic [BUF_SH-1:0] buf_idx,
  input  logic [31:0]       buf_wdata,
  output logic [31:0]       rd_word
);
  logic [31:0] mem_q [WORDS];
  logic [31:0] wbuf_q [BUF_LEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < BUF_LEN; j++) wbuf_q[j] <= '1;
    end else if (buf_we) begin
      wbuf_q[buf_idx] <= buf_wdata;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [AW-1:0] WA = AW'(w);
    logic hit_erase, hit_prog, hit_bufp;
    assign hit_erase = do_erase && ((WA >> BLK_SH) == (addr >> BLK_SH));
    assign hit_prog  = do_prog  && (WA == addr);
    assign hit_bufp  = do_bufp  && ((WA >> BUF_SH) == (addr >> BUF_SH));

    always_ff @(posedge clk) begin
      if (!rst_n)         mem_q[w] <= '1;
      else if (hit_erase) mem_q[w] <= '1;
      else if (hit_prog)  mem_q[w] <= cell_program(mem_q[w], wdata);
      else if (hit_bufp)  mem_q[w] <= cell_program(mem_q[w], wbuf_q[BUF_SH'(w)]);
    end
  end

  assign rd_word = mem_q[addr];
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flash_prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_WORDS  = 32,
  parameter int BUF_LEN    = 32,
  parameter int PROG_CYC   = 4,
  parameter int ERASE_CYC  = 8,
  localparam int NREG    = NUM_BLOCKS / 2,
  localparam int WORDS   = NUM_BLOCKS * BLK_WORDS,
  localparam int AW      = $clog2(WORDS),
  localparam int RW      = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int REG_SH  = $clog2(BLK_WORDS) + 1,
  localparam int BUF_SH  = $clog2(BUF_LEN),
  localparam int BUF_CYC = BUF_LEN * PROG_CYC / 2,
  localparam int CW      = $clog2(BUF_CYC + PROG_CYC + ERASE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  input  logic              buf_we,
  input  logic [BUF_SH-1:0] buf_idx,
  input  logic [31:0]       buf_wdata,
  input  logic [NREG-1:0]   prog_en,
  input  logic [NREG-1:0]   read_en,
  output logic              busy,
  output logic              rd_valid,
  output logic [31:0]       rdata,
  output logic              viol
);
  fop_e          op;
  logic          accept, allow, is_read, is_write, wr_fire, refuse;
  logic [RW-1:0] region;
  logic [CW-1:0] dur;
  logic [31:0]   rd_word;

  assign op     = fop_e'(cmd);
  assign accept = cmd_valid && !busy;
  assign region = RW'(addr >> REG_SH);

  fpc_prot_check #(.NREG(NREG)) prot_i (
    .op(op), .region(region), .prog_en(prog_en), .read_en(read_en),
    .is_read(is_read), .is_write(is_write), .allow(allow)
  );

  assign wr_fire = accept && is_write && allow;
  assign refuse  = accept && (is_read || is_write) && !allow;

  always_comb begin
    unique case (op)
      OP_BUFP:  dur = CW'(BUF_CYC);
      OP_ERASE: dur = CW'(ERASE_CYC);
      default:  dur = CW'(PROG_CYC);
    endcase
  end

  fpc_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(wr_fire), .load_val(dur), .busy(busy)
  );

  fpc_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_WORDS(BLK_WORDS), .BUF_LEN(BUF_LEN)) store_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .do_prog(wr_fire && op == OP_PROG),
    .do_bufp(wr_fire && op == OP_BUFP),
    .do_erase(wr_fire && op == OP_ERASE),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
      viol     <= 1'b0;
    end else begin
      rd_valid <= accept && is_read;
      rdata    <= (accept && is_read && allow) ? rd_word : '0;
      viol     <= refuse;
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int NREG = 4,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd,
  input logic            busy,
  input logic            rd_valid,
  input logic [31:0]     rdata,
  input logic            viol,
  input logic            accept,
  input logic            allow,
  input logic            is_read,
  input logic            is_write,
  input logic            wr_fire,
  input logic [RW-1:0]   region,
  input logic [NREG-1:0] prog_en
);
  assert_refuse_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (is_read || is_write) && !allow |=> viol);

  assert_viol_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(accept && !allow));

  assert_refused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (rdata == 32'd0));

  assert_fetch_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cmd == 3'd2) |=> rd_valid && !viol);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> !rd_valid && !viol);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> busy);

  assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> prog_en[region]);
endmodule

bind flash_prot_ctrl fpc_checker #(.NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .busy(busy),
  .rd_valid(rd_valid), .rdata(rdata), .viol(viol), .accept(accept),
  .allow(allow), .is_read(is_read), .is_write(is_write), .wr_fire(wr_fire),
  .region(region), .prog_en(prog_en)
);

// File: tb/flash_prot_ctrl_tb.sv
module flash_prot_ctrl_tb_top;
  localparam int WORDS = 256, BUFN = 32, PCYC = 4, ECYC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, buf_we = 1'b0;
  logic [2:0] cmd = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, buf_wdata = '0;
  logic [4:0] buf_idx = '0;
  logic [3:0] prog_en = '1, read_en = '1;
  logic busy, rd_valid, viol;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  logic [31:0] ref_mem [WORDS];
  logic [31:0] ref_buf [BUFN];

  always #2.5 clk = ~clk;

  flash_prot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .addr(addr),
    .wdata(wdata), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .prog_en(prog_en), .read_en(read_en), .busy(busy), .rd_valid(rd_valid),
    .rdata(rdata), .viol(viol)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int reg_of(input logic [7:0] a);
    return int'(a) / 64;
  endfunction

  function automatic logic granted(input logic [2:0] c, input logic [7:0] a);
    case (c)
      3'd1, 3'd3: return read_en[reg_of(a)];
      3'd2:       return 1'b1;
      3'd4, 3'd5, 3'd6: return prog_en[reg_of(a)];
      default:    return 1'b0;
    endcase
  endfunction

  function automatic int exp_dur(input logic [2:0] c);
    if (c == 3'd5) return BUFN * PCYC / 2;
    if (c == 3'd6) return ECYC;
    return PCYC;
  endfunction

  task automatic model_write(input logic [2:0] c, input logic [7:0] a,
                             input logic [31:0] d);
    if (c == 3'd4) ref_mem[a] = ref_mem[a] & d;
    else if (c == 3'd5)
      for (int i = 0; i < BUFN; i++)
        ref_mem[(int'(a) / BUFN) * BUFN + i] &= ref_buf[i];
    else if (c == 3'd6)
      for (int i = 0; i < 32; i++) ref_mem[(int'(a) / 32) * 32 + i] = '1;
  endtask

  // Called at a negedge; returns at a negedge with busy low.
  task automatic run(input logic [2:0] c, input logic [7:0] a,
                     input logic [31:0] d, input string tag);
    logic rd_k, wr_k, ok;
    logic [31:0] exp_rd;
    int n;
    rd_k = (c >= 3'd1 && c <= 3'd3);
    wr_k = (c >= 3'd4 && c <= 3'd6);
    ok = granted(c, a);
    exp_rd = (rd_k && ok) ? ref_mem[a] : 32'd0;
    cmd_valid = 1'b1; cmd = c; addr = a; wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wr_k && ok) model_write(c, a, d);
    chk(rd_valid == rd_k, {tag, " R9 rd_valid"}, 32'(rd_valid), 32'(rd_k));
    chk(viol == ((rd_k || wr_k) && !ok), {tag, " R9 viol"}, 32'(viol),
        32'((rd_k || wr_k) && !ok));
    if (rd_k) chk(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    if (wr_k && ok) chk(n == exp_dur(c), {tag, " R10 busy length"}, 32'(n), 32'(exp_dur(c)));
    else chk(n == 0, {tag, " R6 no busy"}, 32'(n), 32'd0);
  endtask

  task automatic load_buf(input logic [4:0] i, input logic [31:0] d);
    buf_we = 1'b1; buf_idx = i; buf_wdata = d;
    ref_buf[i] = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '1;
    for (int i = 0; i < BUFN; i++) ref_buf[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !viol && !rd_valid, "R1 idle outputs", {29'd0, busy, viol, rd_valid}, 32'd0);
    run(3'd1, 8'd0,   0, "R1 read low");
    run(3'd1, 8'd255, 0, "R1 read high");

    // R2 AND-only programming
    run(3'd4, 8'h21, 32'hA5A5F0F0, "R2 first program");
    run(3'd4, 8'h21, 32'h0F0F0F0F, "R2 second program");
    run(3'd1, 8'h21, 0, "R2 readback");
    chk(ref_mem[8'h21] == 32'h05050000, "R2 model value", ref_mem[8'h21], 32'h05050000);
    run(3'd4, 8'h21, 32'hFFFFFFFF, "R2 ones do not set");
    run(3'd1, 8'h21, 0, "R2 readback after ones");

    // R3 buffered program, unaligned address
    for (int i = 0; i < BUFN; i++) load_buf(5'(i), 32'h1000_0000 + 32'(i) * 32'h0101);
    run(3'd5, 8'h45, 0, "R3 buffered program");
    run(3'd1, 8'h40, 0, "R3 first word");
    run(3'd1, 8'h5F, 0, "R3 last word");
    run(3'd1, 8'h60, 0, "R3 beyond window");

    // R4 erase one half of region 1, other half intact
    run(3'd4, 8'h65, 32'h0000FFFF, "R4 setup");
    run(3'd6, 8'h4A, 0, "R4 erase");
    run(3'd1, 8'h45, 0, "R4 erased word");
    run(3'd1, 8'h65, 0, "R4 sibling block kept");
    run(3'd1, 8'h21, 0, "R4 other region kept");

    // R5 and R6 region boundaries with region 1 locked
    prog_en = 4'b1101;
    run(3'd4, 8'h40, 32'h0, "R6 program refused");
    run(3'd6, 8'h7F, 0,     "R6 erase refused");
    run(3'd5, 8'h60, 0,     "R6 buffered refused");
    run(3'd4, 8'h3F, 32'h0, "R5 region0 edge allowed");
    run(3'd4, 8'h80, 32'h0, "R5 region2 edge allowed");
    run(3'd1, 8'h40, 0, "R6 memory unchanged");
    run(3'd1, 8'h65, 0, "R6 memory unchanged 2");

    // R7 read-only region
    run(3'd1, 8'h65, 0, "R7 data read");
    run(3'd3, 8'h65, 0, "R7 debug read");
    run(3'd2, 8'h65, 0, "R7 fetch");

    // R8 execute-only region
    read_en = 4'b1101;
    run(3'd2, 8'h65, 0, "R8 fetch allowed");
    run(3'd1, 8'h65, 0, "R8 data read refused");
    run(3'd3, 8'h40, 0, "R8 debug read refused");
    run(3'd1, 8'h81, 0, "R8 neighbour readable");
    prog_en = '1; read_en = '1;

    // R10 commands while busy are ignored
    cmd_valid = 1'b1; cmd = 3'd4; addr = 8'h90; wdata = 32'h0;
    @(negedge clk);
    ref_mem[8'h90] = 32'h0;
    cmd = 3'd4; addr = 8'h91; wdata = 32'h0;
    @(negedge clk);
    chk(!rd_valid && !viol, "R10 ignored program", {30'd0, rd_valid, viol}, 32'd0);
    cmd = 3'd1; addr = 8'h90;
    @(negedge clk);
    chk(!rd_valid && !viol, "R10 ignored read", {30'd0, rd_valid, viol}, 32'd0);
    cmd = 3'd6; addr = 8'h90;
    @(negedge clk);
    chk(!rd_valid && !viol, "R10 ignored erase", {30'd0, rd_valid, viol}, 32'd0);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    run(3'd1, 8'h91, 0, "R10 word untouched");
    run(3'd1, 8'h90, 0, "R10 erase ignored");

    // Random mix against the model
    for (int k = 0; k < 400; k++) begin
      if (k % 16 == 0) begin
        prog_en = 4'($urandom);
        read_en = 4'($urandom);
      end
      if ($urandom % 8 == 0)
        load_buf(5'($urandom), $urandom | $urandom);
      run(3'($urandom_range(1, 6)), 8'($urandom), $urandom | $urandom, "R5 random op");
    end

    read_en = '1;
    for (int a = 0; a < WORDS; a++) run(3'd1, 8'(a), 0, "R2 R3 R4 final sweep");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule